// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer with Early Warning

This block is a memory-mapped watchdog. A 32-bit down-counter loses one on every cycle in which the tick input is high, as long as counting is switched on. Software kicks the watchdog by writing a fresh starting value into the count register. It can read that register back at any time to see how much of the count remains.

Two sticky interrupt flags are raised. The early-warning flag is set when the descending count lands on a programmed threshold. The timeout flag is set when the count runs out. Each flag stays high until a pulse on its own clear input.

Every write to a control register must come directly after a write of the key word to a dedicated guard register. Without that key write, the control write has no effect. This keeps a runaway program from silencing or starving the watchdog.

Top module: `wdt_keyguard`

## Requirements
- R1: After reset the count, threshold and enable registers read 0 and both interrupt outputs are low.
- R2: A write to the count (0x0), threshold (0x4) or enable (0x8) register that is not immediately preceded by an unlock leaves that register unchanged.
- R3: Writing 0xF1D0DEAD to the guard register (0xC) unlocks exactly one following bus write. Any bus write consumes the unlock: a protected write, a write to an unmapped address, a guard write with another value, or a refused count write.
- R4: Reads are never blocked, and a read between the unlock and the protected write does not cancel the unlock.
- R5: An unlocked write to the count register loads the written value, and reading 0x0 returns the remaining count. An unlocked count write of 0 is refused, because the legal load range is 1 to 0xFFFFFFFF.
- R6: The enable register is bit 0 of offset 0x8. While it is 1, the count drops by exactly one on each cycle with tick high. While it is 0, the count is held.
- R7: The threshold flag is set in the cycle the count decrements to a value equal to a nonzero threshold. A threshold of 0 never sets it.
- R8: The timeout flag is set in the cycle the count decrements from 1 to 0. The counter then stays at 0 until it is reloaded, so one expiry sets the flag once.
- R9: Each flag stays set until a pulse on its clear input. A set event in the same cycle wins over the clear, and a count reload does not clear a pending flag.
- R10: When an unlocked count load and a decrement fall in the same cycle, the loaded value is kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register byte address |
| busWe | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| tick | input | 1 | Count tick enable |
| thrClr | input | 1 | Clear pulse for the threshold flag |
| toClr | input | 1 | Clear pulse for the timeout flag |
| thrIrq | output | 1 | Sticky threshold (early-warning) flag |
| toIrq | output | 1 | Sticky timeout flag |

## Verification
Read data is combinational, so the value of a register is due in the same cycle as its address. The bench samples it in the low phase of the clock, before the edge that could change it.

A write, a decrement and a flag set or clear all take effect at the next rising edge. The bench therefore advances its reference model at that edge and compares the flags and the read data in the next low phase.

Directed sequences cover these cases:
- locked writes;
- a read placed inside the unlock window;
- a refused zero load;
- a load in the same cycle as a tick;
- a threshold of zero;
- expiry followed by further ticks.

Seeded random traffic then mixes all of these.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OFS_CNT  = 'h0;
  localparam int OFS_THR  = 'h4;
  localparam int OFS_EN   = 'h8;
  localparam int OFS_SAFE = 'hC;

  typedef struct packed {
    logic loadCount;
    logic loadThr;
    logic loadEn;
  } ctlStrobes_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'hF1D0DEAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output ctlStrobes_t       strobes
);
  logic armed;
  logic isKey;
  logic granted;

  assign isKey   = busWe && (busAddr == ADDR_W'(OFS_SAFE)) && (busWdata == KEY);
  assign granted = busWe && armed;

  // Any write consumes the unlock; only a key write re-arms it.
  always_ff @(posedge clk) begin
    if (!rstN)      armed <= 1'b0;
    else if (busWe) armed <= isKey;
  end

  always_comb begin
    strobes.loadCount = granted && (busAddr == ADDR_W'(OFS_CNT)) && (busWdata != '0);
    strobes.loadThr   = granted && (busAddr == ADDR_W'(OFS_THR));
    strobes.loadEn    = granted && (busAddr == ADDR_W'(OFS_EN));
  end

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
  // R3
  unlock_consumed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes != '0) |=> !armed);
  // R4
  read_keeps_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !busWe) |=> armed);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              tick,
  input  logic              thrClr,
  input  logic              toClr,
  output logic [DATA_W-1:0] busRdata,
  output logic              thrIrq,
  output logic              toIrq
);
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] thrReg;
  logic              enReg;
  logic              decOk;
  logic [DATA_W-1:0] nextDec;
  logic              thrHit;
  logic              toHit;

  assign decOk   = enReg && tick && (cnt != '0) && !strobes.loadCount;
  assign nextDec = cnt - 1'b1;
  assign thrHit  = decOk && (thrReg != '0) && (nextDec == thrReg);
  assign toHit   = decOk && (nextDec == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      thrReg <= '0;
      enReg  <= 1'b0;
    end else begin
      if (strobes.loadCount) cnt <= busWdata;
      else if (decOk)        cnt <= nextDec;
      if (strobes.loadThr)   thrReg <= busWdata;
      if (strobes.loadEn)    enReg  <= busWdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrIrq <= 1'b0;
      toIrq  <= 1'b0;
    end else begin
      thrIrq <= thrHit | (thrIrq & ~thrClr);
      toIrq  <= toHit  | (toIrq  & ~toClr);
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFS_CNT))     busRdata = cnt;
    else if (busAddr == ADDR_W'(OFS_THR)) busRdata = thrReg;
    else if (busAddr == ADDR_W'(OFS_EN))  busRdata = {{(DATA_W-1){1'b0}}, enReg};
  end

  // R6
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enReg && !strobes.loadCount) |=> $stable(cnt));
  // R6
  step_of_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadCount |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));
  // R8
  timeout_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toIrq) |-> (cnt == '0));
  // R8
  stay_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !strobes.loadCount) |=> (cnt == '0));
  // R9
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toIrq && !toClr) |=> toIrq);
  // R9
  threshold_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (thrIrq && !thrClr) |=> thrIrq);
endmodule

// File: rtl/wdt_keyguard.sv
module wdt_keyguard
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'hF1D0DEAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tick,
  input  logic              thrClr,
  input  logic              toClr,
  output logic              thrIrq,
  output logic              toIrq
);
  ctlStrobes_t strobes;

  wdt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strobes(strobes)
  );

  wdt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .busAddr(busAddr), .tick(tick), .thrClr(thrClr), .toClr(toClr),
    .busRdata(busRdata), .thrIrq(thrIrq), .toIrq(toIrq)
  );
endmodule

// File: tb/wdt_keyguard_bench.sv
module wdt_keyguard_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEYW = 32'hF1D0DEAD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tick = 1'b0, thrClr = 1'b0, toClr = 1'b0;
  logic        thrIrq, toIrq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  string tag = "R1";

  // reference state
  logic [31:0] mCnt = '0, mThr = '0;
  logic        mEn = 1'b0, mArmed = 1'b0, mThrF = 1'b0, mToF = 1'b0;

  wdt_keyguard u_wdt_keyguard (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .tick(tick),
    .thrClr(thrClr), .toClr(toClr), .thrIrq(thrIrq), .toIrq(toIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expRead(input logic [3:0] a);
    case (a)
      4'h0:    return mCnt;
      4'h4:    return mThr;
      4'h8:    return {31'b0, mEn};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle (we are in the low phase), check, advance model at the edge.
  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d,
                     input logic tk, input logic tc, input logic oc);
    logic        acc, dec;
    logic [31:0] nd;
    logic        thrSet, toSet;
    busWe = we; busAddr = a; busWdata = d; tick = tk; thrClr = tc; toClr = oc;
    #1;
    check({tag, " rdata"}, busRdata, expRead(a));
    acc = we && mArmed;
    dec = mEn && tk && (mCnt != 0) && !(acc && a == 4'h0 && d != 0);
    nd = mCnt - 1;
    thrSet = dec && (mThr != 0) && (nd == mThr);
    toSet  = dec && (nd == 0);
    @(posedge clk);
    if (acc && a == 4'h0 && d != 0) mCnt = d;
    else if (dec) mCnt = nd;
    if (acc && a == 4'h4) mThr = d;
    if (acc && a == 4'h8) mEn = d[0];
    if (we) mArmed = (a == 4'hC) && (d == KEYW);
    mThrF = thrSet | (mThrF & ~tc);
    mToF  = toSet  | (mToF  & ~oc);
    @(negedge clk);
    check({tag, " thrIrq"}, {31'b0, thrIrq}, {31'b0, mThrF});
    check({tag, " toIrq"},  {31'b0, toIrq},  {31'b0, mToF});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic rd(input logic [3:0] a);
    cyc(1'b0, a, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic uwr(input logic [3:0] a, input logic [31:0] d);
    wr(4'hC, KEYW);
    wr(a, d);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    tag = "R1"; rd(4'h0); rd(4'h4); rd(4'h8);
    // R2 locked writes ignored
    tag = "R2"; wr(4'h0, 32'd40); wr(4'h8, 32'd1); wr(4'h4, 32'd5); rd(4'h0); rd(4'h8);
    // R5 load and readback, zero refused
    tag = "R5"; uwr(4'h0, 32'd20); rd(4'h0); uwr(4'h0, 32'd0); rd(4'h0);
    // R3 consumed by unmapped write, wrong key
    tag = "R3"; wr(4'hC, KEYW); wr(4'h2, 32'h1); wr(4'h0, 32'd9); rd(4'h0);
    wr(4'hC, 32'hF1D0DEAC); wr(4'h0, 32'd9); rd(4'h0);
    wr(4'hC, KEYW); wr(4'h0, 32'd0); wr(4'h0, 32'd9); rd(4'h0);
    // R4 read inside unlock window
    tag = "R4"; wr(4'hC, KEYW); rd(4'h0); rd(4'h8); wr(4'h4, 32'd5); rd(4'h4);
    // R6 enable / hold
    tag = "R6"; ticks(3); rd(4'h0); uwr(4'h8, 32'd1); ticks(4); rd(4'h0);
    uwr(4'h8, 32'd0); ticks(3); rd(4'h0); uwr(4'h8, 32'd1);
    // R10 load with tick same cycle
    tag = "R10"; wr(4'hC, KEYW); cyc(1'b1, 4'h0, 32'd12, 1'b1, 1'b0, 1'b0); rd(4'h0);
    // R7 threshold 5 reached, R8 expiry
    tag = "R7"; ticks(7); rd(4'h0);
    tag = "R8"; ticks(8); rd(4'h0);
    // R9 reload keeps flags, clear pulses
    tag = "R9"; uwr(4'h0, 32'd30); rd(4'h0);
    cyc(1'b0, 4'h0, 0, 1'b0, 1'b1, 1'b0); cyc(1'b0, 4'h0, 0, 1'b0, 1'b0, 1'b1);
    // R7 threshold zero never fires
    tag = "R7"; uwr(4'h4, 32'd0); uwr(4'h0, 32'd3); ticks(6);
    tag = "R9"; cyc(1'b0, 4'h0, 0, 1'b0, 1'b0, 1'b1);
    // random mix
    tag = "RND";
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [3:0] a;
      logic [31:0] d;
      sel = $urandom_range(0, 99);
      a = 4'($urandom_range(0, 3) * 4);
      if ($urandom_range(0, 19) == 0) a = 4'($urandom_range(0, 15));
      case (a)
        4'h0: d = ($urandom_range(0, 9) == 0) ? 32'd0 : 32'($urandom_range(1, 40));
        4'h4: d = 32'($urandom_range(0, 20));
        4'h8: d = 32'($urandom_range(0, 3));
        default: d = $urandom;
      endcase
      if (sel < 20)      cyc(1'b1, 4'hC, KEYW, $urandom_range(0, 1) == 1, 1'b0, 1'b0);
      else if (sel < 40) cyc(1'b1, a, d, $urandom_range(0, 1) == 1,
                             $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0);
      else               cyc(1'b0, a, 32'h0, $urandom_range(0, 9) < 8,
                             $urandom_range(0, 20) == 0, $urandom_range(0, 20) == 0);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule